// File: doc/BRIEF.md
# Alternating-Polarity Ripple Adder

This block adds two N-bit operands and a carry-in and returns an (N+1)-bit result. It is a ripple-carry chain of full-adder cells, written out stage by stage. The full adder is self-dual: if all three inputs are complemented, both outputs come out complemented. The chain uses this property. Every odd-numbered stage works on complemented operand bits and a complemented carry, and it emits a complemented carry. The carry passed between stages therefore alternates in polarity, and each boundary carries exactly one inversion. Each odd stage flips its local sum bit back, so the visible sum bits are always in true polarity.

A one-bit mode input selects how the top result bit is formed. In unsigned mode the top bit is the final carry out of the chain. In signed mode both operands are treated as sign-extended by one bit. The top bit is then formed from the two operand sign bits and the carry into that position. The parameter N must be even and at least 2. Any other value stops elaboration with an error.

Top module: `alt_inv_adder`

## Requirements
- R1: With mode = 0 (unsigned), sum equals opa + opb + cin as an (N+1)-bit unsigned value, with both operands zero-extended.
- R2: With mode = 1 (signed), sum equals the (N+1)-bit two's-complement value of opa + opb + cin, with both operands sign-extended by one bit.
- R3: sum[N-1:0] is the same in both modes for the same opa, opb and cin. Only sum[N] depends on mode.
- R4: In unsigned mode, sum[N] is the carry out of bit N-1. For example, opa = all ones, opb = 0 and cin = 1 give sum = 1 followed by N zeros.
- R5: In signed mode, sum[N] equals opa[N-1] XOR opb[N-1] XOR the carry out of bit N-1. For example, opa = 0 and opb = all ones give 0 followed by N ones in unsigned mode, and all N+1 bits set in signed mode.
- R6: The carry ripples through every stage. With opb = all ones and cin = 0, changing opa from 0 to 1 moves the unsigned sum from 0 followed by N ones to 1 followed by N zeros.
- R7: Every sum bit is in true polarity at every position, whether its stage is odd or even. A lone set bit at position k in opa, with opb = 0 and cin = 0, gives a lone set bit at position k of sum.
- R8: The carry-in adds exactly one in both modes. With opa = opb = 0, cin = 1 gives sum = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| mode | input | 1 | 0 = unsigned operands, 1 = signed operands |
| sum | output | N+1 | Result, with the top bit chosen by mode |

## Verification
The hardest case to reach is a carry that enters at bit 0 and has to cross every stage, so that each alternating inversion affects the result. A single faulty inversion at an odd or even boundary shows up only when the carry actually travels through that boundary. The stimulus sweeps every operand pair and carry-in for a 4-bit instance in both modes, which covers every propagate run. It also drives the all-ones-plus-one transitions on a 16-bit instance, alongside random vectors for that instance. A walking single bit confirms that each stage restores true polarity on its own sum output.

// File: rtl/alt_adder_pkg.sv
package alt_adder_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } num_mode_e;

    typedef struct packed {
        logic p;
        logic q;
        logic c;
    } fa_in_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    // Majority of three bits, used when checking carry values.
    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // A stage with an odd index runs on complemented signals.
    function automatic bit stage_is_odd(input int idx);
        return (idx % 2) == 1;
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell
    import alt_adder_pkg::*;
(
    input  fa_in_t  din,
    output fa_out_t dout
);
    logic nand_pq;
    logic nand_pc;
    logic nand_qc;

    // Carry built as a NAND-NAND majority; sum as a three-input XOR.
    assign nand_pq   = ~(din.p & din.q);
    assign nand_pc   = ~(din.p & din.c);
    assign nand_qc   = ~(din.q & din.c);
    assign dout.carry = ~(nand_pq & nand_pc & nand_qc);
    assign dout.sum   = din.p ^ din.q ^ din.c;

    always_comb begin
        // R1
        fa_count_chk: assert ({dout.carry, dout.sum} ==
                              (2'({1'b0, din.p}) + 2'({1'b0, din.q}) + 2'({1'b0, din.c})))
            else $error("full-adder output is not the count of high inputs");
    end
endmodule

// File: rtl/alt_stage.sv
module alt_stage
    import alt_adder_pkg::*;
#(
    parameter int INDEX = 0
) (
    input  logic p,
    input  logic q,
    input  logic link_in,
    output logic link_out,
    output logic sum_bit
);
    localparam bit ODD    = stage_is_odd(INDEX);
    localparam bit FIRST  = (INDEX == 0);
    // The incoming link is complemented when it comes from an odd stage.
    localparam bit IN_INV = !FIRST && !ODD;

    fa_in_t  core_in;
    fa_out_t core_out;
    logic    core_c;

    generate
        if (FIRST) begin : g_head
            assign core_c = link_in;
        end else begin : g_link
            // One inversion per stage boundary.
            assign core_c = ~link_in;
        end

        if (ODD) begin : g_odd
            assign core_in = '{p: ~p, q: ~q, c: core_c};
            assign sum_bit = ~core_out.sum;
        end else begin : g_even
            assign core_in = '{p: p, q: q, c: core_c};
            assign sum_bit = core_out.sum;
        end
    endgenerate

    fa_cell u_cell (
        .din  (core_in),
        .dout (core_out)
    );

    assign link_out = core_out.carry;

    logic c_true;
    assign c_true = link_in ^ IN_INV;

    always_comb begin
        // R7
        stage_sum_chk: assert (sum_bit == (p ^ q ^ c_true))
            else $error("stage %0d sum bit not in true polarity", INDEX);
        // R6
        carry_polarity_chk: assert ((link_out ^ ODD) == majority3(p, q, c_true))
            else $error("stage %0d outgoing carry has wrong polarity", INDEX);
    end
endmodule

// File: rtl/carry_chain.sv
module carry_chain
    import alt_adder_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] low_sum,
    output logic         carry_top
);
    logic [N-1:0] link;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_stage
            if (k == 0) begin : g_first
                alt_stage #(.INDEX(k)) u_stage (
                    .p        (a[k]),
                    .q        (b[k]),
                    .link_in  (cin),
                    .link_out (link[k]),
                    .sum_bit  (low_sum[k])
                );
            end else begin : g_rest
                alt_stage #(.INDEX(k)) u_stage (
                    .p        (a[k]),
                    .q        (b[k]),
                    .link_in  (link[k-1]),
                    .link_out (link[k]),
                    .sum_bit  (low_sum[k])
                );
            end
        end
    endgenerate

    // N is even, so the last stage is odd and its carry is complemented.
    assign carry_top = ~link[N-1];

    logic [N:0] ref_unsigned;
    assign ref_unsigned = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

    always_comb begin
        // R4
        chain_total_chk: assert ({carry_top, low_sum} == ref_unsigned)
            else $error("carry chain total differs from the arithmetic sum");
    end
endmodule

// File: rtl/msb_select.sv
module msb_select
    import alt_adder_pkg::*;
(
    input  logic      a_msb,
    input  logic      b_msb,
    input  logic      carry_top,
    input  num_mode_e mode,
    output logic      top_bit
);
    always_comb begin
        case (mode)
            MODE_SIGNED: top_bit = a_msb ^ b_msb ^ carry_top;
            default:     top_bit = carry_top;
        endcase
    end
endmodule

// File: rtl/alt_inv_adder.sv
module alt_inv_adder
    import alt_adder_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    input  logic         cin,
    input  logic         mode,
    output logic [N:0]   sum
);
    localparam int W = N + 1;

    generate
        if ((N < 2) || ((N % 2) != 0)) begin : g_bad_width
            $error("alt_inv_adder: N must be even and at least 2");
        end
    endgenerate

    num_mode_e    mode_e;
    logic [N-1:0] low_sum;
    logic         carry_top;
    logic         top_bit;

    assign mode_e = num_mode_e'(mode);

    carry_chain #(.N(N)) u_chain (
        .a         (opa),
        .b         (opb),
        .cin       (cin),
        .low_sum   (low_sum),
        .carry_top (carry_top)
    );

    msb_select u_msb (
        .a_msb     (opa[N-1]),
        .b_msb     (opb[N-1]),
        .carry_top (carry_top),
        .mode      (mode_e),
        .top_bit   (top_bit)
    );

    assign sum = {top_bit, low_sum};

    logic [W-1:0] ref_u;
    logic [W-1:0] ref_s;
    assign ref_u = {1'b0, opa} + {1'b0, opb} + {{N{1'b0}}, cin};
    assign ref_s = {opa[N-1], opa} + {opb[N-1], opb} + {{N{1'b0}}, cin};

    always_comb begin
        // R1
        unsigned_sum_chk: assert (mode || (sum == ref_u))
            else $error("unsigned result mismatch");
        // R2
        signed_sum_chk: assert (!mode || (sum == ref_s))
            else $error("signed result mismatch");
        // R3
        low_bits_chk: assert (sum[N-1:0] == ref_u[N-1:0])
            else $error("low result bits depend on mode");
    end
endmodule

// File: tb/tb_alt_inv_adder.sv
module tb_alt_inv_adder;

    logic clk = 1'b0;
    always #10ns clk = ~clk;

    logic rst;

    logic [3:0]  a4, b4;
    logic        c4, m4;
    logic [4:0]  s4;
    logic [15:0] a16, b16;
    logic        c16, m16;
    logic [16:0] s16;

    int checks = 0;
    int errors = 0;

    alt_inv_adder #(.N(4)) dut (
        .opa (a4), .opb (b4), .cin (c4), .mode (m4), .sum (s4)
    );

    alt_inv_adder #(.N(16)) dut_wide (
        .opa (a16), .opb (b16), .cin (c16), .mode (m16), .sum (s16)
    );

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp4(input logic [3:0] a, input logic [3:0] b,
                                        input logic c, input logic m);
        logic [4:0] r;
        if (m) r = {a[3], a} + {b[3], b} + {4'd0, c};
        else   r = {1'b0, a} + {1'b0, b} + {4'd0, c};
        return r;
    endfunction

    function automatic logic [16:0] exp16(input logic [15:0] a, input logic [15:0] b,
                                          input logic c, input logic m);
        logic [16:0] r;
        if (m) r = {a[15], a} + {b[15], b} + {16'd0, c};
        else   r = {1'b0, a} + {1'b0, b} + {16'd0, c};
        return r;
    endfunction

    task automatic drive4(input logic [3:0] a, input logic [3:0] b, input logic c, input logic m);
        @(posedge clk);
        #1ns;
        a4 = a; b4 = b; c4 = c; m4 = m;
        @(negedge clk);
    endtask

    task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c, input logic m);
        @(posedge clk);
        #1ns;
        a16 = a; b16 = b; c16 = c; m16 = m;
        @(negedge clk);
    endtask

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary_and_end();
    end

    initial begin
        logic [4:0] low_u;
        rst = 1'b1;
        a4 = '0; b4 = '0; c4 = 1'b0; m4 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0; m16 = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Idle inputs give a zero result (R1).
        @(negedge clk);
        check("R1 idle zero", {12'd0, s4}, 17'd0);
        check("R1 idle zero wide", s16, 17'd0);

        // R8: carry-in alone.
        drive4(4'd0, 4'd0, 1'b1, 1'b0);
        check("R8 cin unsigned", {12'd0, s4}, 17'd1);
        drive4(4'd0, 4'd0, 1'b1, 1'b1);
        check("R8 cin signed", {12'd0, s4}, 17'd1);

        // R4: all ones plus carry-in.
        drive4(4'hF, 4'h0, 1'b1, 1'b0);
        check("R4 top carry", {12'd0, s4}, 17'h10);
        drive16(16'hFFFF, 16'h0000, 1'b1, 1'b0);
        check("R4 top carry wide", s16, 17'h10000);

        // R5: different signs.
        drive4(4'h0, 4'hF, 1'b0, 1'b0);
        check("R5 unsigned ref", {12'd0, s4}, 17'h0F);
        drive4(4'h0, 4'hF, 1'b0, 1'b1);
        check("R5 signed top", {12'd0, s4}, 17'h1F);
        drive16(16'h7FFF, 16'h7FFF, 1'b0, 1'b1);
        check("R5 signed positive", s16, 17'h0FFFE);

        // R6: full carry ripple transition.
        drive4(4'h0, 4'hF, 1'b0, 1'b0);
        check("R6 before", {12'd0, s4}, 17'h0F);
        drive4(4'h1, 4'hF, 1'b0, 1'b0);
        check("R6 after", {12'd0, s4}, 17'h10);
        drive16(16'h0000, 16'hFFFF, 1'b0, 1'b0);
        check("R6 before wide", s16, 17'h0FFFF);
        drive16(16'h0001, 16'hFFFF, 1'b0, 1'b0);
        check("R6 after wide", s16, 17'h10000);

        // R7: walking single bit through each stage.
        for (int k = 0; k < 16; k++) begin
            drive16(16'(1) << k, 16'h0000, 1'b0, 1'b0);
            check("R7 walking bit", s16, 17'(1) << k);
        end

        // R1, R2, R3: exhaustive 4-bit sweep in both modes.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    drive4(4'(a), 4'(b), 1'(c), 1'b0);
                    check("R1 exhaustive", {12'd0, s4}, {12'd0, exp4(4'(a), 4'(b), 1'(c), 1'b0)});
                    low_u = s4;
                    drive4(4'(a), 4'(b), 1'(c), 1'b1);
                    check("R2 exhaustive", {12'd0, s4}, {12'd0, exp4(4'(a), 4'(b), 1'(c), 1'b1)});
                    check("R3 low bits", {13'd0, s4[3:0]}, {13'd0, low_u[3:0]});
                end
            end
        end

        // R1, R2: random 16-bit vectors.
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] ra, rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            drive16(ra, rb, rc, 1'b0);
            check("R1 random wide", s16, exp16(ra, rb, rc, 1'b0));
            drive16(ra, rb, rc, 1'b1);
            check("R2 random wide", s16, exp16(ra, rb, rc, 1'b1));
        end

        summary_and_end();
    end

endmodule